// File: doc/BRIEF.md
# Quadratic Polynomial Evaluator

This block evaluates the second-order polynomial `C*x*x + B*x + A` on unsigned operands. The operands arrive one at a time on a shared data input. A small controller steps through a fixed schedule on a datapath that has four operand registers, two 4-to-1 operand selectors, a two-input add/multiply unit and one result register.

The user places a value on `din` and raises `go`. The value is captured while `go` is high. The controller then waits in a holding state until `go` falls, and only then moves to the next operand. The operands are taken in the order A, B, C, x. When `go` falls after the x operand, five single-cycle arithmetic steps follow without further input. The last step writes `result`. The controller then returns to waiting for a new A.

Only the A and B registers may take an intermediate value. The schedule is therefore B←B·x, A←A+B, B←C·x, B←B·x, result←A+B. Every arithmetic step keeps the low `DATA_W` bits, so results wrap modulo 2^`DATA_W`.

Top module: `quad_eval`

## Requirements
- R1: While `rst_n` is low at a rising edge, `result` is cleared to 0 and the controller returns to waiting for operand A; a sequence that was partly loaded is abandoned.
- R2: Operands are taken in the order A, B, C, x. Each is the value on `din` at the last rising edge at which `go` is seen high in that operand's load phase. The value written to `result` is (C·x·x + B·x + A) mod 2^`DATA_W`.
- R3: While `go` stays high after a capture, changes on `din` have no effect on the captured operand.
- R4: `result` changes at the sixth rising edge counted from the edge that first samples `go` low after the x capture; that sampling edge counts as the first.
- R5: `result` holds its value at all times except at the single edge of R4, including while the next operand set is being loaded.
- R6: After each evaluation, the block accepts a new operand set without a reset.
- R7: Values that exceed 2^`DATA_W`−1 wrap; no intermediate or final value saturates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| go | input | 1 | Capture strobe; held high to capture, released to advance |
| din | input | DATA_W | Shared operand input |
| result | output | DATA_W | Registered polynomial value |

## Verification
A table of operand sets is run back to back without reset, and each evaluation is compared with a model computed in the bench. The sets are chosen so that each of A, B, C and x contributes a distinct term. A wrong selector code, a wrong schedule step or a swapped load order therefore gives a different number. Some sets are large enough to wrap, which separates truncating arithmetic from saturating or widened arithmetic. Directed cases cover the following:
- changing `din` while `go` is held, which exposes loading in the holding state;
- a reset in the middle of loading;
- the exact edge at which `result` moves, which exposes an extra or a missing schedule step.

// File: rtl/quad_pkg.sv
package quad_pkg;

    typedef enum logic [3:0] {
        ST_LA, ST_LA_W, ST_LB, ST_LB_W,
        ST_LC, ST_LC_W, ST_LX, ST_LX_W,
        ST_M0, ST_M1, ST_M2, ST_M3, ST_M4
    } state_e;

    localparam logic [1:0] SEL_A = 2'd0;
    localparam logic [1:0] SEL_B = 2'd1;
    localparam logic [1:0] SEL_C = 2'd2;
    localparam logic [1:0] SEL_X = 2'd3;

    localparam logic OP_ADD = 1'b0;
    localparam logic OP_MUL = 1'b1;

    localparam int NUM_PORTS = 2;

    typedef struct packed {
        logic       ld_a;
        logic       ld_b;
        logic       ld_c;
        logic       ld_x;
        logic       ld_r;
        logic       use_alu;
        logic [1:0] sel_p;
        logic [1:0] sel_q;
        logic       op;
    } ctl_t;

endpackage

// File: rtl/quad_alu.sv
module quad_alu #(
    parameter int W = 8
) (
    input  logic [W-1:0] p,
    input  logic [W-1:0] q,
    input  logic         op,
    output logic [W-1:0] y
);
    import quad_pkg::*;

    localparam int PW = 2 * W;

    logic [PW-1:0] prod;
    logic [W-1:0]  sum;

    always_comb begin
        prod = PW'(p) * PW'(q);
        sum  = p + q;
        y    = (op == OP_MUL) ? prod[W-1:0] : sum;
    end

endmodule

// File: rtl/quad_opmux.sv
module quad_opmux #(
    parameter int W = 8
) (
    input  logic [1:0]   sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] c,
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    import quad_pkg::*;

    always_comb begin
        case (sel)
            SEL_A:   y = a;
            SEL_B:   y = b;
            SEL_C:   y = c;
            default: y = x;
        endcase
    end

endmodule

// File: rtl/quad_ctrl.sv
module quad_ctrl (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    output quad_pkg::ctl_t  ctl
);
    import quad_pkg::*;

    typedef struct packed {
        state_e st;
    } cstate_t;

    cstate_t s_d, s_q;

    // next state
    always_comb begin
        s_d = s_q;
        case (s_q.st)
            ST_LA:   s_d.st = go ? ST_LA_W : ST_LA;
            ST_LA_W: s_d.st = go ? ST_LA_W : ST_LB;
            ST_LB:   s_d.st = go ? ST_LB_W : ST_LB;
            ST_LB_W: s_d.st = go ? ST_LB_W : ST_LC;
            ST_LC:   s_d.st = go ? ST_LC_W : ST_LC;
            ST_LC_W: s_d.st = go ? ST_LC_W : ST_LX;
            ST_LX:   s_d.st = go ? ST_LX_W : ST_LX;
            ST_LX_W: s_d.st = go ? ST_LX_W : ST_M0;
            ST_M0:   s_d.st = ST_M1;
            ST_M1:   s_d.st = ST_M2;
            ST_M2:   s_d.st = ST_M3;
            ST_M3:   s_d.st = ST_M4;
            default: s_d.st = ST_LA;
        endcase
    end

    // control decode: everything idle unless the state says otherwise
    always_comb begin
        ctl = '0;
        case (s_q.st)
            ST_LA: ctl.ld_a = 1'b1;
            ST_LB: ctl.ld_b = 1'b1;
            ST_LC: ctl.ld_c = 1'b1;
            ST_LX: ctl.ld_x = 1'b1;
            ST_M0: begin // B <- B*x
                ctl.ld_b = 1'b1; ctl.use_alu = 1'b1;
                ctl.sel_p = SEL_B; ctl.sel_q = SEL_X; ctl.op = OP_MUL;
            end
            ST_M1: begin // A <- A+B
                ctl.ld_a = 1'b1; ctl.use_alu = 1'b1;
                ctl.sel_p = SEL_A; ctl.sel_q = SEL_B; ctl.op = OP_ADD;
            end
            ST_M2: begin // B <- C*x
                ctl.ld_b = 1'b1; ctl.use_alu = 1'b1;
                ctl.sel_p = SEL_C; ctl.sel_q = SEL_X; ctl.op = OP_MUL;
            end
            ST_M3: begin // B <- B*x
                ctl.ld_b = 1'b1; ctl.use_alu = 1'b1;
                ctl.sel_p = SEL_B; ctl.sel_q = SEL_X; ctl.op = OP_MUL;
            end
            ST_M4: begin // R <- A+B
                ctl.ld_r = 1'b1;
                ctl.sel_p = SEL_A; ctl.sel_q = SEL_B; ctl.op = OP_ADD;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_LA};
        else        s_q <= s_d;
    end

    assert_one_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctl.ld_a, ctl.ld_b, ctl.ld_c, ctl.ld_x, ctl.ld_r}));

    assert_wait_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((s_q.st inside {ST_LA_W, ST_LB_W, ST_LC_W, ST_LX_W}) && go)
        |=> (s_q.st == $past(s_q.st)));

    assert_start_compute_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_LX_W && !go) |=> (s_q.st == ST_M0));

    assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_M4) |=> (s_q.st == ST_LA));

endmodule

// File: rtl/quad_dpath.sv
module quad_dpath #(
    parameter int W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  quad_pkg::ctl_t ctl,
    input  logic [W-1:0]   din,
    output logic [W-1:0]   result
);
    import quad_pkg::*;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] c;
        logic [W-1:0] x;
        logic [W-1:0] r;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]   sel   [NUM_PORTS];
    logic [W-1:0] opnd  [NUM_PORTS];
    logic [W-1:0] alu_y;

    assign sel[0] = ctl.sel_p;
    assign sel[1] = ctl.sel_q;

    for (genvar i = 0; i < NUM_PORTS; i++) begin : g_port
        quad_opmux #(.W(W)) u_mux (
            .sel (sel[i]),
            .a   (r_q.a),
            .b   (r_q.b),
            .c   (r_q.c),
            .x   (r_q.x),
            .y   (opnd[i])
        );
    end

    quad_alu #(.W(W)) u_alu (
        .p  (opnd[0]),
        .q  (opnd[1]),
        .op (ctl.op),
        .y  (alu_y)
    );

    always_comb begin
        r_d = r_q;
        if (ctl.ld_a) r_d.a = ctl.use_alu ? alu_y : din;
        if (ctl.ld_b) r_d.b = ctl.use_alu ? alu_y : din;
        if (ctl.ld_c) r_d.c = din;
        if (ctl.ld_x) r_d.x = din;
        if (ctl.ld_r) r_d.r = alu_y;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign result = r_q.r;

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (r_q.r == '0));

    assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ld_r |=> $stable(r_q.r));

    assert_c_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ld_c |=> $stable(r_q.c));

    assert_x_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ld_x |=> $stable(r_q.x));

endmodule

// File: rtl/quad_eval.sv
module quad_eval #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] result
);
    import quad_pkg::*;

    ctl_t ctl;

    quad_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (go),
        .ctl   (ctl)
    );

    quad_dpath #(.W(DATA_W)) u_dpath (
        .clk    (clk),
        .rst_n  (rst_n),
        .ctl    (ctl),
        .din    (din),
        .result (result)
    );

endmodule

// File: tb/quad_eval_test.sv
`timescale 1ns/1ps
module quad_eval_test;

    localparam int W = 8;
    localparam int NV = 8;
    // {A, B, C, x}
    localparam logic [31:0] VEC [NV] = '{
        {8'd1,  8'd2,  8'd3,  8'd4},
        {8'd7,  8'd0,  8'd0,  8'd9},
        {8'd0,  8'd5,  8'd0,  8'd6},
        {8'd0,  8'd0,  8'd2,  8'd7},
        {8'd3,  8'd1,  8'd1,  8'd1},
        {8'd10, 8'd3,  8'd16, 8'd16},
        {8'd200,8'd100,8'd50, 8'd7},
        {8'd255,8'd255,8'd255,8'd255}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go = 1'b0;
    logic [W-1:0] din = '0;
    logic [W-1:0] result;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    quad_eval #(.DATA_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .din(din), .result(result)
    );

    function automatic logic [W-1:0] model(int a, int b, int c, int x);
        return W'((c * x * x + b * x + a) % 256);
    endfunction

    task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load(logic [W-1:0] v);
        @(negedge clk);
        din = v; go = 1'b1;
        repeat (2) @(negedge clk);
        go = 1'b0;
    endtask

    // capture v, then keep go high while din wanders
    task automatic load_hold(logic [W-1:0] v);
        @(negedge clk);
        din = v; go = 1'b1;
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            din = W'(v + 8'd37 + W'(k));
            @(negedge clk);
        end
        go = 1'b0;
    endtask

    task automatic run(logic [W-1:0] a, logic [W-1:0] b, logic [W-1:0] c,
                       logic [W-1:0] x, string tag);
        logic [W-1:0] prev, exp;
        prev = result;
        exp = model(a, b, c, x);
        load(a); load(b); load(c);
        #1 check({tag, " R5 hold during load"}, result, prev);
        load(x);
        repeat (5) @(posedge clk);
        #1;
        if (exp != prev) check({tag, " R4 not before sixth edge"}, result, prev);
        @(posedge clk);
        #1 check({tag, " R2 R4 value at sixth edge"}, result, exp);
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset result", result, '0);
        rst_n = 1'b1;

        // table walk, back to back, no reset between sets (R6, R7 in wrap rows)
        for (int i = 0; i < NV; i++) begin
            run(VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                $sformatf("vec%0d R6 R7", i));
        end

        // R3: din changes while go held are ignored, for every operand
        @(negedge clk);
        load_hold(8'd4); load_hold(8'd3); load_hold(8'd2);
        load_hold(8'd5);
        repeat (6) @(posedge clk);
        #1 check("R3 wait ignores din", result, model(4, 3, 2, 5));

        // R1: reset in mid-load abandons the partial set and clears result
        load(8'd90); load(8'd91);
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 mid-load reset clears result", result, '0);
        rst_n = 1'b1;
        run(8'd6, 8'd1, 8'd2, 8'd3, "R1 restart at A");

        // R5: result stays put across many idle cycles
        repeat (20) @(negedge clk);
        check("R5 idle hold", result, model(6, 1, 2, 3));

        done = 1'b1;
        finish_up();
    end

endmodule